// File: doc/BRIEF.md
# Serial Register Access Port with Selectable Bit Order

This block lets an external host read and write a small internal byte-wide register file over a four-wire serial link: serial clock, host-to-slave data, slave-to-host data and an active-low select. Every access begins with a 16-bit command. The first bit on the wire is the direction flag, where 1 means read. The second bit is the burst flag. The last 14 bits are the starting register address. Data bytes follow the command: the host sends them on a write, and the block returns them on a read.

A static swap input sets the bit order of the address and data fields. When swap is high the most significant bit goes first. When it is low the least significant bit goes first. The direction and burst flags keep their positions whatever the swap setting. The serial pins share package pins with a parallel bus. For that reason the block drives its data-out line only in serial mode while the select is low, and it ignores all serial activity when the mode-select input is low.

All link inputs are brought into the system clock domain through two-flop synchronizers, and serial clock edges are found by comparing successive synchronized samples. The link uses SPI mode 0: the block samples the host's data on the rising serial edge and updates its data-out line after the falling serial edge.

Top module: `spi_regacc`

## Requirements
- R1: A frame holds a 16-bit command followed by 8-bit data. On the wire, command bit 0 is the direction flag (1 = read, 0 = write), command bit 1 is the burst flag, and command bits 2 to 15 carry a 14-bit address. A write stores its data byte at the address, and a later read frame to that address returns the byte. All registers hold 0x00 after reset.
- R2: With swap = 1, the address and data fields travel most-significant bit first. With swap = 0, they travel least-significant bit first. A value written under one setting reads back unchanged under the other.
- R3: With the burst flag set, the address advances by one after every complete data byte until the select rises, on both reads and writes.
- R4: With the burst flag clear, exactly one data byte is transferred. Any further bits in the same frame are ignored, and the next register is left unchanged.
- R5: The select rising at any point ends the frame. A write byte that arrived only partly is discarded, and the next frame starts again with a fresh command.
- R6: While the mode-select input is 0, no serial frame reaches the register file and the data-out line is never enabled.
- R7: The data-out enable is high only while the mode-select input is 1 and the select is low. It falls within 4 system clocks after the select rises. It is 0 after reset, and the data-out line is 0 after reset.
- R8: The register file holds 16 entries. Writes to address 16 or above are ignored, and reads from those addresses return 0x00.
- R9: Read data changes only after a falling serial clock edge. The first data bit is valid at the first rising edge after the command ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_en | input | 1 | Serial mode select; 1 enables the port |
| bit_swap | input | 1 | 1 = address/data sent MSB first, 0 = LSB first |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the shared data-out pin |

## Verification
The bench builds the block with its default parameters: a 16-bit command, 8-bit data and a 16-entry register file. The default depth is small next to the 14-bit address space, so a burst that runs past entry 15 and a single access to a high address both reach the out-of-range path. The serial clock runs at 16 system clocks per period, which leaves room for the synchronizer and edge-detector latency before each sampling point. That spacing lets the bench cross swap settings between writes and reads, cut frames short at chosen bit counts, and switch serial mode off in the middle of a sequence.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

  parameter int CTRL_W = 16;
  parameter int DATA_W = 8;
  parameter int ADDR_W = CTRL_W - 2;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_HOLD = 2'd2
  } phase_t;

  function automatic logic [ADDR_W-1:0] flip_addr(input logic [ADDR_W-1:0] v);
    logic [ADDR_W-1:0] r;
    for (int i = 0; i < ADDR_W; i++) r[i] = v[ADDR_W-1-i];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] flip_byte(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/spi_regacc_sync.sv
module spi_regacc_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_regacc_regfile.sv
module spi_regacc_regfile
  import spi_regacc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              in_range;
  logic [IW-1:0]     idx;

  assign in_range = (addr < ADDR_W'(DEPTH));
  assign idx      = addr[IW-1:0];

  genvar e;
  generate
    for (e = 0; e < DEPTH; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && in_range && (idx == IW'(e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem_q[e] <= '0;
        else if (hit) mem_q[e] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = in_range ? mem_q[idx] : '0;

  // R8: an access beyond the last entry leaves the addressed storage untouched
  a_r8_oor_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range && (idx == '0)) |=> $stable(mem_q[0]));

endmodule

// File: rtl/spi_regacc_frame.sv
module spi_regacc_frame
  import spi_regacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              swap,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo
);

  localparam int             CW       = $clog2(CTRL_W);
  localparam int             DIW      = $clog2(DATA_W);
  localparam logic [CW-1:0]  CMD_LAST = CW'(CTRL_W - 1);
  localparam logic [CW-1:0]  DAT_LAST = CW'(DATA_W - 1);

  phase_t              phase_q, phase_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [CTRL_W-2:0]   sh_q, sh_d;
  logic                rd_q, rd_d;
  logic                burst_q, burst_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                sdo_q, sdo_d;
  logic                sclk_q;
  logic                rise, fall;
  logic [CTRL_W-1:0]   cmd_word;
  logic [DATA_W-1:0]   in_byte;
  logic [DATA_W-1:0]   out_ord;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign cmd_word = {sh_q, mosi_s};
  assign in_byte  = {sh_q[DATA_W-2:0], mosi_s};
  assign out_ord  = swap ? flip_byte(rd_data) : rd_data;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    burst_d = burst_q;
    addr_d  = addr_q;
    sdo_d   = sdo_q;
    wr_en   = 1'b0;
    wr_data = swap ? in_byte : flip_byte(in_byte);
    if (!active) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
      sdo_d   = 1'b0;
    end else if (rise) begin
      sh_d = {sh_q[CTRL_W-3:0], mosi_s};
      cnt_d = cnt_q + 1'b1;
      unique case (phase_q)
        PH_CMD: if (cnt_q == CMD_LAST) begin
          rd_d    = cmd_word[CTRL_W-1];
          burst_d = cmd_word[CTRL_W-2];
          addr_d  = swap ? cmd_word[ADDR_W-1:0] : flip_addr(cmd_word[ADDR_W-1:0]);
          phase_d = PH_DATA;
          cnt_d   = '0;
        end
        PH_DATA: if (cnt_q == DAT_LAST) begin
          wr_en = ~rd_q;
          cnt_d = '0;
          if (burst_q) addr_d  = addr_q + 1'b1;
          else         phase_d = PH_HOLD;
        end
        default: cnt_d = cnt_q;
      endcase
    end else if (fall) begin
      sdo_d = (phase_q == PH_DATA) && rd_q && out_ord[cnt_q[DIW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      sdo_q   <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      burst_q <= burst_d;
      addr_q  <= addr_d;
      sdo_q   <= sdo_d;
      sclk_q  <= sclk_s;
    end
  end

  assign addr = addr_q;
  assign sdo  = sdo_q;

  // R3: the bit counter stays inside one byte during the data phase
  a_r3_byte_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |-> (cnt_q <= DAT_LAST));

  // R4: a single-byte write parks the frame until the select rises
  a_r4_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !burst_q && active) |=> (phase_q == PH_HOLD));

  // R5: losing the select restarts command collection
  a_r5_abort_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (phase_q == PH_CMD) && (cnt_q == '0));

  // R9: data-out only moves after a falling serial edge or on frame end
  a_r9_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fall) |=> $stable(sdo_q));

endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
  import spi_regacc_pkg::*;
#(
  parameter int REG_DEPTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en,
  input  logic bit_swap,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);

  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic [2:0]        link_s;
  logic              cs_s, sclk_s, mosi_s;
  logic              active;
  logic [ADDR_W-1:0] rf_addr;
  logic              rf_wr;
  logic [DATA_W-1:0] rf_wdata, rf_rdata;
  logic              oe_q, oe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  spi_regacc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_s),
    .din  ({cs_n, sclk, mosi}),
    .dout (link_s)
  );
  assign {cs_s, sclk_s, mosi_s} = link_s;

  assign active = ser_en & ~cs_s;

  spi_regacc_frame u_frame (
    .clk    (clk),
    .rst_n  (rst_s),
    .active (active),
    .swap   (bit_swap),
    .sclk_s (sclk_s),
    .mosi_s (mosi_s),
    .rd_data(rf_rdata),
    .addr   (rf_addr),
    .wr_en  (rf_wr),
    .wr_data(rf_wdata),
    .sdo    (miso)
  );

  spi_regacc_regfile #(.DEPTH(REG_DEPTH)) u_regs (
    .clk    (clk),
    .rst_n  (rst_s),
    .addr   (rf_addr),
    .wr_en  (rf_wr),
    .wr_data(rf_wdata),
    .rd_data(rf_rdata)
  );

  always_comb oe_d = active;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end
  assign miso_oe = oe_q;

  // R7: a high select releases the shared pin on the next clock
  a_r7_release_pin: assert property (@(posedge clk) disable iff (!rst_s)
    cs_s |=> !miso_oe);

  // R6: with serial mode off nothing reaches the register file
  a_r6_no_store: assert property (@(posedge clk) disable iff (!rst_s)
    (!ser_en && $past(!ser_en)) |-> !rf_wr);

endmodule

// File: tb/spi_regacc_test.sv
module spi_regacc_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b1;
  logic bit_swap = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regacc uut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .bit_swap(bit_swap),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: drive mosi, sample miso just before the rising edge
  task automatic bit_xfer(input logic b, output logic got);
    mosi = b;
    wait_clk(HALF_SCK);
    got  = miso;
    sclk = 1'b1;
    wait_clk(HALF_SCK);
    sclk = 1'b0;
  endtask

  task automatic sel_low();
    cs_n = 1'b0;
    wait_clk(HALF_SCK);
  endtask

  task automatic sel_high();
    wait_clk(HALF_SCK);
    cs_n = 1'b1;
    wait_clk(2 * HALF_SCK);
  endtask

  task automatic send_cmd(input logic rd, input logic burst, input logic [13:0] a);
    logic g;
    bit_xfer(rd, g);
    bit_xfer(burst, g);
    for (int i = 0; i < 14; i++) bit_xfer(bit_swap ? a[13-i] : a[i], g);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    logic g;
    for (int i = 0; i < n; i++) bit_xfer(bit_swap ? v[7-i] : v[i], g);
  endtask

  task automatic recv_byte();
    logic [7:0] v;
    logic g;
    for (int i = 0; i < 8; i++) begin
      bit_xfer(1'b0, g);
      if (bit_swap) v[7-i] = g; else v[i] = g;
    end
    obs_q.push_back(v);
  endtask

  task automatic wr1(input logic [13:0] a, input logic [7:0] v);
    sel_low(); send_cmd(1'b0, 1'b0, a); send_bits(v, 8); sel_high();
  endtask

  task automatic expect_rd(input logic [13:0] a, input logic [7:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
    sel_low(); send_cmd(1'b1, 1'b0, a); recv_byte(); sel_high();
  endtask

  // monitor: compares returned bytes against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        logic [7:0] got, want;
        string t;
        got = obs_q.pop_front();
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected", int'(got), 0);
        end else begin
          want = exp_q.pop_front();
          t    = tag_q.pop_front();
          check(got == want, t, int'(got), int'(want));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R7 reset state of the pin pair
    check(miso_oe == 1'b0, "R7 reset oe", int'(miso_oe), 0);
    check(miso == 1'b0, "R7 reset data", int'(miso), 0);
    // R1 reset content
    expect_rd(14'd3, 8'h00, "R1 reset value");

    // R1 / R2 least-significant first
    bit_swap = 1'b0;
    wr1(14'd2, 8'hA5);
    expect_rd(14'd2, 8'hA5, "R1 lsb-first write/read");

    // R2 most-significant first and cross-order
    bit_swap = 1'b1;
    wr1(14'd5, 8'h3C);
    expect_rd(14'd5, 8'h3C, "R2 msb-first");
    wr1(14'd6, 8'h01);
    bit_swap = 1'b0;
    expect_rd(14'd6, 8'h01, "R2 cross order");
    expect_rd(14'd5, 8'h3C, "R2 cross order");

    // R3 burst write then burst read, with oe checked mid-frame (R7)
    bit_swap = 1'b1;
    sel_low(); send_cmd(1'b0, 1'b1, 14'd8);
    send_bits(8'h11, 8); send_bits(8'h22, 8); send_bits(8'h33, 8); sel_high();
    exp_q.push_back(8'h11); tag_q.push_back("R3 burst 0");
    exp_q.push_back(8'h22); tag_q.push_back("R3 burst 1");
    exp_q.push_back(8'h33); tag_q.push_back("R3 burst 2");
    sel_low();
    check(miso_oe == 1'b1, "R7 oe during frame", int'(miso_oe), 1);
    send_cmd(1'b1, 1'b1, 14'd8);
    recv_byte(); recv_byte(); recv_byte();
    sel_high();
    check(miso_oe == 1'b0, "R7 oe after select", int'(miso_oe), 0);
    check(miso == 1'b0, "R7 data idle", int'(miso), 0);

    // R4 single-byte frame ignores trailing bytes
    bit_swap = 1'b0;
    sel_low(); send_cmd(1'b0, 1'b0, 14'd12);
    send_bits(8'h77, 8); send_bits(8'h88, 8); sel_high();
    expect_rd(14'd12, 8'h77, "R4 first byte");
    expect_rd(14'd13, 8'h00, "R4 next reg untouched");

    // R5 aborts: mid-data and mid-command, then a clean frame
    sel_low(); send_cmd(1'b0, 1'b0, 14'd2); send_bits(8'hFF, 5); sel_high();
    expect_rd(14'd2, 8'hA5, "R5 partial byte dropped");
    sel_low(); send_bits(8'hFF, 7); sel_high();
    wr1(14'd4, 8'h6E);
    expect_rd(14'd4, 8'h6E, "R5 restart after cut command");

    // R6 serial mode off
    ser_en = 1'b0;
    wait_clk(4);
    sel_low();
    send_cmd(1'b0, 1'b0, 14'd2);
    check(miso_oe == 1'b0, "R6 pin not driven", int'(miso_oe), 0);
    send_bits(8'h5A, 8);
    sel_high();
    ser_en = 1'b1;
    wait_clk(4);
    expect_rd(14'd2, 8'hA5, "R6 write ignored");

    // R8 out-of-range write and read; burst running past last entry
    wr1(14'd100, 8'h99);
    expect_rd(14'd100, 8'h00, "R8 high address reads zero");
    expect_rd(14'd4, 8'h6E, "R8 alias untouched");
    sel_low(); send_cmd(1'b0, 1'b1, 14'd15);
    send_bits(8'hE1, 8); send_bits(8'hE2, 8); sel_high();
    expect_rd(14'd15, 8'hE1, "R8 last entry");
    expect_rd(14'd0, 8'h00, "R8 no wrap into entry 0");

    // R9 first data bit valid right after the command (bit 0 of 0x01, lsb first)
    bit_swap = 1'b0;
    sel_low(); send_cmd(1'b1, 1'b0, 14'd6);
    begin
      logic g;
      bit_xfer(1'b0, g);
      check(g == 1'b1, "R9 first read bit", int'(g), 1);
      bit_xfer(1'b0, g);
      check(g == 1'b0, "R9 second read bit", int'(g), 0);
    end
    sel_high();

    wait_clk(20);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule